// File: doc/BRIEF.md
# Serial Flash Discovery Initializer

This block brings an attached SPI NOR flash into service after power-up. One `start` pulse makes it issue a fixed series of flash commands through a separate command engine. First it reads the three-byte manufacturer/device identifier. If the identifier marks a vendor whose parts ship with block protection set, it enables writes and sends the global unprotect command. It then polls the status register until the device is idle. Next it reads and validates the discoverable-parameter header, follows the header's pointer to the basic parameter table, and accepts the device only if the table reports 4 KiB erase with opcode 0x20 and 3-byte addressing. On success it derives the capacity in bytes from the table's density word.

The block talks to the engine over two streams. Each command travels on a valid/ready request channel that carries the opcode, the address, the address length and the expected number of response bytes. Once a request is accepted, `cmd_op`, `cmd_addr`, `cmd_addr_bytes` and `cmd_rx_len` must stay constant until the handshake; they do not change while `cmd_valid` is high and `cmd_ready` is low. The engine returns data bytes on a valid/ready response channel. The block raises `rsp_ready` only while it waits for the transaction it has issued, and the engine may stall between bytes by lowering `rsp_valid`. The engine signals the end of a transaction with a one-cycle `xfer_done`, issued in a cycle after the last response byte was accepted. Only one command is outstanding at any time.

Top module: `flash_probe_init`

## Requirements
- R1: After `start`, the first command is opcode 0x9F with zero address bytes and `cmd_rx_len`=3. The first returned byte is taken as the vendor code.
- R2: If the vendor code is 0xBF, the block sends opcode 0x06 (0 address, 0 response bytes). It then sends status reads (opcode 0x05, 1 response byte) until bit 1 of the status is set, and then opcode 0x98 (0 address, 0 response bytes). For any other code none of these commands appear. If POLL_LIMIT status reads in a row show bit 1 clear, the run ends in error.
- R3: The block then sends status reads (0x05, 1 byte) until bit 0 of the status reads 0. If POLL_LIMIT reads in a row return bit 0 set, the run ends in error and no further command is sent.
- R4: The header read is opcode 0x5A with 4 address bytes, address 0 and `cmd_rx_len`=16. Bytes 0..3 must be 0x53,0x46,0x44,0x50 and byte 5 must be 0x01, else the run ends in error.
- R5: Header byte 8 must be 0x00 and header byte 10 must be 0x01, else the run ends in error without a table read.
- R6: The table read is opcode 0x5A, 4 address bytes, `cmd_rx_len`=8, at `cmd_addr` = {hdr[14],hdr[13],hdr[12],8'h00}.
- R7: Table byte 0 bits [1:0] must be 2'b01 and table byte 1 must be 0x20, else error.
- R8: Table byte 2 bit 2 and table byte 7 bit 7 must both be 0, else error.
- R9: On success, `size_bytes` = D/8 + 1 (integer division), where D = {t7,t6,t5,t4} taken little-endian from table bytes 4..7. The value holds until the next successful run.
- R10: `done` is high for exactly one cycle at the end of every run. `error` is set in that same cycle and stays set until the next accepted `start`. `busy` is high from the cycle after `start` until `done`. A `start` while busy is ignored.
- R11: Request fields stay stable while `cmd_valid` is high and `cmd_ready` is low. The block never requests a command while it is accepting response bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the discovery sequence (taken when idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Sticky failure flag of the last run |
| size_bytes | output | 32 | Device capacity in bytes |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | 32 | Address, sent most-significant byte first |
| cmd_addr_bytes | output | 3 | Number of address bytes (0 or 4) |
| cmd_rx_len | output | 5 | Number of response bytes expected |
| rsp_valid | input | 1 | Response byte valid |
| rsp_ready | output | 1 | Block accepts response bytes |
| rsp_data | input | 8 | Response byte |
| xfer_done | input | 1 | Engine finished the current transaction |

## Verification
The bench builds the block with POLL_LIMIT=4. That small limit lets it sweep the status-poll loops across every busy and write-latch delay from zero to beyond the limit, so both sides of each timeout boundary are reached. A behavioural engine stalls the request channel and the response channel on alternate cycles. The bench sweeps a single-bit corruption over every header byte, all four erase-size codes against two erase opcodes, both address-mode flags, and a range of density values whose capacities are computed arithmetically.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  localparam logic [7:0] OP_READ_ID   = 8'h9F;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_STATUS    = 8'h05;
  localparam logic [7:0] OP_UNPROTECT = 8'h98;
  localparam logic [7:0] OP_DISCOVER  = 8'h5A;
  localparam logic [7:0] ERASE_4K_OP  = 8'h20;
  localparam logic [7:0] LOCKED_VENDOR = 8'hBF;
  localparam int         RX_BYTES     = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID_REQ, ST_ID_WAIT, ST_WEN_REQ, ST_WEN_WAIT,
    ST_WEL_REQ, ST_WEL_WAIT, ST_UNP_REQ, ST_UNP_WAIT, ST_BSY_REQ,
    ST_BSY_WAIT, ST_HDR_REQ, ST_HDR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_DONE
  } probe_state_e;
endpackage

// File: rtl/flash_probe_rxbuf.sv
module flash_probe_rxbuf #(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic [DEPTH*8-1:0] bytes_o
);
  localparam int IDXW = $clog2(DEPTH + 1);

  logic [IDXW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 idx <= '0;
    else if (clear)                             idx <= '0;
    else if (wr_en && idx < IDXW'(DEPTH))       idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               bytes_o[g*8 +: 8] <= '0;
      else if (!clear && wr_en && idx == IDXW'(g)) bytes_o[g*8 +: 8] <= wr_data;
    end
  end

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDXW'(DEPTH));
endmodule

// File: rtl/flash_probe_check.sv
module flash_probe_check
  import flash_probe_pkg::*;
(
  input  logic [RX_BYTES*8-1:0] bytes_i,
  output logic                  hdr_ok,
  output logic [31:0]           tbl_ptr,
  output logic                  tbl_ok,
  output logic [31:0]           size_calc
);
  logic [7:0] b [RX_BYTES];
  logic       sig_ok, ver_ok, idx_ok, erase_ok, addr_ok;
  logic [31:0] density;
  logic        unused_bits;

  for (genvar g = 0; g < RX_BYTES; g++) begin : g_split
    assign b[g] = bytes_i[g*8 +: 8];
  end

  assign sig_ok   = {b[0], b[1], b[2], b[3]} == 32'h5346_4450;
  assign ver_ok   = b[5] == 8'h01;
  assign idx_ok   = (b[8] == 8'h00) && (b[10] == 8'h01);
  assign hdr_ok   = sig_ok && ver_ok && idx_ok;
  assign tbl_ptr  = {b[14], b[13], b[12], 8'h00};

  assign erase_ok = (b[0][1:0] == 2'b01) && (b[1] == ERASE_4K_OP);
  assign addr_ok  = !b[2][2] && !b[7][7];
  assign tbl_ok   = erase_ok && addr_ok;
  assign density  = {b[7], b[6], b[5], b[4]};
  assign size_calc = (density >> 3) + 32'd1;

  assign unused_bits = ^{b[3], b[9], b[11], b[15]};
endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import flash_probe_pkg::*;
#(
  parameter int POLL_LIMIT = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [31:0] size_bytes,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_op,
  output logic [31:0] cmd_addr,
  output logic [2:0]  cmd_addr_bytes,
  output logic [4:0]  cmd_rx_len,
  output logic        rsp_ready,
  input  logic        xfer_done,
  input  logic [7:0]  first_byte,
  input  logic        hdr_ok,
  input  logic [31:0] tbl_ptr,
  input  logic        tbl_ok,
  input  logic [31:0] size_calc,
  output logic        buf_clear
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);

  probe_state_e    state;
  logic [PCW-1:0]  polls;
  logic            last_poll;

  assign last_poll = polls == PCW'(POLL_LIMIT - 1);

  always_comb begin
    cmd_valid = 1'b1; cmd_op = OP_STATUS; cmd_addr = '0;
    cmd_addr_bytes = 3'd0; cmd_rx_len = 5'd1;
    unique case (state)
      ST_ID_REQ:  begin cmd_op = OP_READ_ID; cmd_rx_len = 5'd3; end
      ST_WEN_REQ: begin cmd_op = OP_WR_ENABLE; cmd_rx_len = 5'd0; end
      ST_UNP_REQ: begin cmd_op = OP_UNPROTECT; cmd_rx_len = 5'd0; end
      ST_WEL_REQ, ST_BSY_REQ: ;
      ST_HDR_REQ: begin cmd_op = OP_DISCOVER; cmd_addr_bytes = 3'd4; cmd_rx_len = 5'd16; end
      ST_TBL_REQ: begin
        cmd_op = OP_DISCOVER; cmd_addr_bytes = 3'd4; cmd_rx_len = 5'd8; cmd_addr = tbl_ptr;
      end
      default:    cmd_valid = 1'b0;
    endcase
  end

  assign rsp_ready = state inside {ST_ID_WAIT, ST_WEN_WAIT, ST_WEL_WAIT, ST_UNP_WAIT,
                                   ST_BSY_WAIT, ST_HDR_WAIT, ST_TBL_WAIT};
  assign buf_clear = cmd_valid && cmd_ready;
  assign busy      = state != ST_IDLE;
  assign done      = state == ST_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; polls <= '0; error <= 1'b0; size_bytes <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin state <= ST_ID_REQ; error <= 1'b0; polls <= '0; end
        ST_ID_REQ, ST_WEN_REQ, ST_WEL_REQ, ST_UNP_REQ, ST_BSY_REQ, ST_HDR_REQ, ST_TBL_REQ:
          if (cmd_ready) state <= probe_state_e'(state + 4'd1);
        ST_ID_WAIT: if (xfer_done)
          state <= (first_byte == LOCKED_VENDOR) ? ST_WEN_REQ : ST_BSY_REQ;
        ST_WEN_WAIT: if (xfer_done) state <= ST_WEL_REQ;
        ST_WEL_WAIT: if (xfer_done) begin
          if (first_byte[1])  begin state <= ST_UNP_REQ; polls <= '0; end
          else if (last_poll) begin state <= ST_DONE; error <= 1'b1; end
          else begin state <= ST_WEL_REQ; polls <= polls + 1'b1; end
        end
        ST_UNP_WAIT: if (xfer_done) state <= ST_BSY_REQ;
        ST_BSY_WAIT: if (xfer_done) begin
          if (!first_byte[0]) begin state <= ST_HDR_REQ; polls <= '0; end
          else if (last_poll) begin state <= ST_DONE; error <= 1'b1; end
          else begin state <= ST_BSY_REQ; polls <= polls + 1'b1; end
        end
        ST_HDR_WAIT: if (xfer_done) begin
          if (hdr_ok) state <= ST_TBL_REQ;
          else begin state <= ST_DONE; error <= 1'b1; end
        end
        ST_TBL_WAIT: if (xfer_done) begin
          state <= ST_DONE;
          if (tbl_ok) size_bytes <= size_calc;
          else        error <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr)
      && $stable(cmd_addr_bytes) && $stable(cmd_rx_len));
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);
  assert_poll_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    polls < PCW'(POLL_LIMIT));
  assert_tbl_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_addr_bytes == 3'd4 |-> cmd_addr[7:0] == 8'h00);
endmodule

// File: rtl/flash_probe_init.sv
module flash_probe_init
  import flash_probe_pkg::*;
#(
  parameter int POLL_LIMIT = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [31:0] size_bytes,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_op,
  output logic [31:0] cmd_addr,
  output logic [2:0]  cmd_addr_bytes,
  output logic [4:0]  cmd_rx_len,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_data,
  input  logic        xfer_done
);
  logic [RX_BYTES*8-1:0] rx_bytes;
  logic                  buf_clear, hdr_ok, tbl_ok;
  logic [31:0]           tbl_ptr, size_calc;

  flash_probe_rxbuf #(.DEPTH(RX_BYTES)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear),
    .wr_en(rsp_valid && rsp_ready), .wr_data(rsp_data), .bytes_o(rx_bytes)
  );

  flash_probe_check u_check (
    .bytes_i(rx_bytes), .hdr_ok(hdr_ok), .tbl_ptr(tbl_ptr),
    .tbl_ok(tbl_ok), .size_calc(size_calc)
  );

  flash_probe_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .size_bytes(size_bytes), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_rx_len(cmd_rx_len),
    .rsp_ready(rsp_ready), .xfer_done(xfer_done), .first_byte(rx_bytes[7:0]),
    .hdr_ok(hdr_ok), .tbl_ptr(tbl_ptr), .tbl_ok(tbl_ok),
    .size_calc(size_calc), .buf_clear(buf_clear)
  );
endmodule

// File: tb/flash_probe_init_tb.sv
module flash_probe_init_tb;
  localparam int LIM = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, error, cmd_valid, rsp_ready;
  logic [31:0] size_bytes, cmd_addr;
  logic [7:0] cmd_op;
  logic [2:0] cmd_addr_bytes;
  logic [4:0] cmd_rx_len;
  logic cmd_ready = 0, rsp_valid = 0, xfer_done = 0;
  logic [7:0] rsp_data = 0;

  always #5 clk = ~clk;

  flash_probe_init #(.POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .size_bytes(size_bytes), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_rx_len(cmd_rx_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .xfer_done(xfer_done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] id_b [3];
  logic [7:0] hdr [16];
  logic [7:0] tbl [8];
  int wel_delay, busy_n, wel_left, busy_left;
  bit wel_phase;
  logic [7:0] op_log [64];
  logic [31:0] tbl_addr_seen;
  int log_n, eng_tick;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(input logic [7:0] op, input logic [31:0] a, input int i);
    if (op == 8'h9F) return id_b[i];
    if (op == 8'h5A) return (a == 0) ? hdr[i] : tbl[i];
    return 8'h00;
  endfunction

  // behavioural command engine with stalls on both channels
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [7:0] op; logic [31:0] a; logic [2:0] ab; logic [4:0] n; logic [7:0] st;
        op = cmd_op; a = cmd_addr; ab = cmd_addr_bytes; n = cmd_rx_len;
        eng_tick++;
        if (eng_tick % 2 == 1) begin
          @(negedge clk);
          chk(cmd_valid && cmd_op == op && cmd_addr == a && cmd_addr_bytes == ab && cmd_rx_len == n,
              "R11", "request held under stall", {cmd_op, cmd_rx_len}, {op, n});
        end
        cmd_ready = 1; @(negedge clk); cmd_ready = 0;
        if (log_n < 64) op_log[log_n] = op;
        log_n++;
        if (op == 8'h5A && a != 0) tbl_addr_seen = a;
        if (op == 8'h5A) chk(ab == 3'd4 && n == (a == 0 ? 5'd16 : 5'd8), "R4", "discovery read shape", {ab, n}, 0);
        if (op == 8'h06) wel_phase = 1;
        if (op == 8'h98) wel_phase = 0;
        st = 8'h00;
        if (op == 8'h05) begin
          if (wel_phase) begin st = (wel_left == 0) ? 8'h02 : 8'h00; if (wel_left > 0) wel_left--; end
          else begin st = (busy_left > 0) ? 8'h01 : 8'h00; if (busy_left > 0) busy_left--; end
        end
        for (int i = 0; i < int'(n); i++) begin
          bit acc;
          rsp_valid = 1; rsp_data = (op == 8'h05) ? st : resp_byte(op, a, i);
          forever begin acc = rsp_ready; @(negedge clk); if (acc) break; end
          if (i % 2 == 1) begin rsp_valid = 0; @(negedge clk); end
        end
        rsp_valid = 0;
        @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
      end
    end
  end

  task automatic set_good();
    id_b = '{8'hC2, 8'h28, 8'h17};
    hdr = '{8'h53, 8'h46, 8'h44, 8'h50, 8'h06, 8'h01, 8'h01, 8'hFF,
            8'h00, 8'h06, 8'h01, 8'h10, 8'h30, 8'h00, 8'h00, 8'hFF};
    tbl = '{8'hE5, 8'h20, 8'hF1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    wel_delay = 0; busy_n = 0;
  endtask

  task automatic run_case(input string tag);
    bit hdr_good, tbl_good, wel_fail, busy_fail, exp_err, seq_ok;
    logic [7:0] exp_ops [64];
    int en, cyc, k;
    logic [31:0] dens;
    hdr_good = {hdr[0], hdr[1], hdr[2], hdr[3]} == "SFDP" && hdr[5] == 1 && hdr[8] == 0 && hdr[10] == 1;
    tbl_good = tbl[0][1:0] == 2'b01 && tbl[1] == 8'h20 && !tbl[2][2] && !tbl[7][7];
    wel_fail = id_b[0] == 8'hBF && wel_delay >= LIM;
    busy_fail = busy_n >= LIM;
    exp_err = wel_fail || busy_fail || !hdr_good || !tbl_good;
    en = 0; exp_ops[en++] = 8'h9F;
    if (id_b[0] == 8'hBF) begin
      exp_ops[en++] = 8'h06;
      k = wel_fail ? LIM : wel_delay + 1;
      repeat (k) exp_ops[en++] = 8'h05;
      if (!wel_fail) exp_ops[en++] = 8'h98;
    end
    if (!wel_fail) begin
      k = busy_fail ? LIM : busy_n + 1;
      repeat (k) exp_ops[en++] = 8'h05;
      if (!busy_fail) begin
        exp_ops[en++] = 8'h5A;
        if (hdr_good) exp_ops[en++] = 8'h5A;
      end
    end
    log_n = 0; tbl_addr_seen = 32'hFFFF_FFFF;
    wel_phase = 0; wel_left = wel_delay; busy_left = busy_n;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(done, "R10", {tag, " done reached"}, done, 1);
    chk(error == exp_err, tag, "error outcome", error, exp_err);
    seq_ok = log_n == en;
    for (int i = 0; i < en && i < log_n; i++) if (op_log[i] != exp_ops[i]) seq_ok = 0;
    chk(seq_ok, (id_b[0] == 8'hBF) ? "R2" : "R3", {tag, " command order R1"}, log_n, en);
    if (hdr_good && !wel_fail && !busy_fail)
      chk(tbl_addr_seen == {hdr[14], hdr[13], hdr[12], 8'h00}, "R6", "table address",
          tbl_addr_seen, {hdr[14], hdr[13], hdr[12], 8'h00});
    if (!exp_err) begin
      dens = {tbl[7], tbl[6], tbl[5], tbl[4]};
      chk(size_bytes == dens / 8 + 1, "R9", "size in bytes", size_bytes, dens / 8 + 1);
    end
    @(negedge clk);
    chk(!done && !busy, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    log_n = 0; eng_tick = 0;
    set_good();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !error && !cmd_valid && size_bytes == 0, "R10", "reset state",
        {busy, done, error, cmd_valid}, 0);

    set_good(); run_case("R1");
    set_good(); id_b[0] = 8'hBF; wel_delay = 1; busy_n = 2; run_case("R2");
    for (int b = 0; b <= LIM + 1; b++) begin set_good(); busy_n = b; run_case("R3"); end
    for (int w = 0; w <= LIM + 1; w++) begin set_good(); id_b[0] = 8'hBF; wel_delay = w; run_case("R2"); end
    for (int k = 0; k < 16; k++) begin
      set_good(); hdr[k] = hdr[k] ^ 8'h01;
      run_case((k == 8 || k == 10) ? "R5" : "R4");
    end
    for (int e = 0; e < 4; e++)
      for (int o = 0; o < 2; o++) begin
        set_good(); tbl[0] = {tbl[0][7:2], 2'(e)}; tbl[1] = o ? 8'hD8 : 8'h20; run_case("R7");
      end
    set_good(); tbl[2][2] = 1'b1; run_case("R8");
    set_good(); tbl[7][7] = 1'b1; run_case("R8");
    for (int s = 0; s < 8; s++) begin
      logic [31:0] d;
      d = (32'h1 << (13 + 2 * s)) - 1;
      set_good(); {tbl[7], tbl[6], tbl[5], tbl[4]} = d; run_case("R9");
    end
    set_good(); {tbl[7], tbl[6], tbl[5], tbl[4]} = 32'h0012_3457; run_case("R9");

    // error persists while idle, clears on next start; start while busy ignored
    set_good(); hdr[0] = 8'h00; run_case("R10");
    repeat (5) @(negedge clk);
    chk(error, "R10", "error sticky while idle", error, 1);
    set_good();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(!error && busy, "R10", "error cleared on start", {error, busy}, 2'b01);
    repeat (6) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R10", "no restart from start while busy", busy, 0);
    repeat (40) @(negedge clk);
    chk(!busy && !cmd_valid, "R10", "stays idle after run", {busy, cmd_valid}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule